// File: doc/BRIEF.md
# Status Register and Write-Permission Guard

This block keeps the eight-bit status byte of a serial memory and decides, every cycle, whether a write may proceed. It produces separate permits for writing the status byte itself and for writing the target address. The target is either the main array or, when the identification-select bit is set, a small identification page. A command decoder drives it with one-cycle strobes: arm, disarm, stage a status write, and start the internal cycle when the chip select is released. The memory controller adds an end-of-write pulse, an end-of-access pulse and a busy flag. The block's outputs are the status byte, which can be shifted out at any time, the two permits, and the page-select level used to steer addresses.

The protection inputs come from four sources: the write-arm latch, a hardware guard pin that is active low, a pin-enable bit, and a two-bit block-protect field. The lock and block-protect bits stand in for non-volatile cells and are plain flops here. A status write is staged first and applied only when the internal cycle starts. A hardware guard that becomes active in between cancels it.

Top module: `memstat_guard`

## Requirements
- R1: After a synchronous reset, `stat_o` is 0x00, and `sr_ok_o`, `arr_ok_o` and `id_sel_o` are 0.
- R2: An arm strobe sets status bit 1 (write-arm). A disarm strobe clears it. If both strobes come in the same cycle, disarm wins.
- R3: Status bit positions are: 7 pin-enable, 6 identification-select, 5 constant 0, 4 page lock, 3:2 block-protect, 1 write-arm, 0 busy. Bit 0 equals `busy_i` delayed by one cycle. `id_sel_o` equals bit 6.
- R4: A status write changes only bits 7, 6, 4, 3 and 2, and it clears write-arm. It is accepted only when write-arm is 1 and the guard is not active. The guard is active when pin-enable is 1 and `guard_pin_n` is 0. `sr_ok_o` shows this condition, registered one cycle.
- R5: A staged status write is dropped if the guard becomes active before `cycle_go`. A guard change after the write has been applied has no effect on it.
- R6: When identification-select is 0, `arr_ok_o` (registered one cycle from `addr_i`) is 1 exactly when write-arm is 1 and the address lies outside the protected range. Block-protect 00 protects nothing, 01 protects 0xC000-0xFFFF, 10 protects 0x8000-0xFFFF, and 11 protects everything. The guard pin and pin-enable do not affect this permit.
- R7: When identification-select is 1, `arr_ok_o` is 1 exactly when write-arm is 1, page lock is 0, block-protect is not 11, and the offset `addr_i[6:0]` lies outside the protected range.
- R8: A status write whose data has both bit 6 and bit 4 set leaves identification-select and page lock unchanged. Its other bits still apply.
- R9: Once set, page lock is never cleared by a status write.
- R10: `wr_done` clears write-arm and identification-select. `xfer_done` clears identification-select only.
- R11: While `busy_i` is 1, the arm, disarm and stage strobes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| guard_pin_n | input | 1 | Hardware write-guard pin, active low |
| cmd_wen | input | 1 | Arm strobe |
| cmd_wdis | input | 1 | Disarm strobe |
| sr_stage | input | 1 | Stage a status write with `sr_data` |
| sr_data | input | 8 | Status write data |
| cycle_go | input | 1 | Internal cycle starts (select released) |
| wr_done | input | 1 | Array or identification-page write finished |
| xfer_done | input | 1 | Read or write access finished |
| busy_i | input | 1 | Internal write in progress |
| addr_i | input | AW | Target address of a requested write |
| stat_o | output | 8 | Status byte |
| sr_ok_o | output | 1 | Status write permitted |
| arr_ok_o | output | 1 | Write to the addressed location permitted |
| id_sel_o | output | 1 | Identification page selected |

## Verification
A vector table walks every block-protect code and probes addresses on both sides of each range boundary, which separates the quarter, half and full decodes. The guard pin is toggled with pin-enable both set and clear, so that a permit that wrongly depends on the pin shows up in the array path and a permit that ignores the pin shows up in the status path. Status writes carrying both page bits, a set lock followed by a write of zero, and the identification-page path under lock and full protection exercise the special page rules. Directed cases then cover a guard that falls between staging and start, a guard that falls after the write has been applied, and strobes that arrive while busy.

// File: rtl/memstat_pkg.sv
package memstat_pkg;
  localparam int B_PINEN = 7;
  localparam int B_IDSEL = 6;
  localparam int B_ZERO  = 5;
  localparam int B_LOCK  = 4;
  localparam int B_BPHI  = 3;
  localparam int B_BPLO  = 2;
  localparam int B_ARM   = 1;
  localparam int B_BUSY  = 0;

  typedef enum logic [1:0] {
    PROT_NONE = 2'b00,
    PROT_QTR  = 2'b01,
    PROT_HALF = 2'b10,
    PROT_ALL  = 2'b11
  } prot_e;
endpackage

// File: rtl/memstat_range.sv
module memstat_range #(
  parameter int AW = 16
) (
  input  logic [AW-1:0]         addr_i,
  input  memstat_pkg::prot_e    bp_i,
  output logic                  hit_o
);
  import memstat_pkg::*;

  always_comb begin
    case (bp_i)
      PROT_NONE: hit_o = 1'b0;
      PROT_QTR:  hit_o = &addr_i[AW-1:AW-2];
      PROT_HALF: hit_o = addr_i[AW-1];
      default:   hit_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/memstat_regs.sv
module memstat_regs (
  input  logic               clk,
  input  logic               rst,
  input  logic               pin_n_i,
  input  logic               cmd_wen,
  input  logic               cmd_wdis,
  input  logic               sr_stage,
  input  logic [7:0]         sr_data,
  input  logic               cycle_go,
  input  logic               wr_done,
  input  logic               xfer_done,
  input  logic               busy_i,
  output logic               pin_en_o,
  output logic               id_sel_o,
  output logic               lock_o,
  output memstat_pkg::prot_e bp_o,
  output logic               arm_o,
  output logic               busy_bit_o
);
  import memstat_pkg::*;

  logic       pin_en_q, id_sel_q, lock_q, arm_q, busy_q;
  prot_e      bp_q;
  logic       pend_q;
  logic [7:0] pend_d;
  logic       hw_guard, stage_ok, do_commit, both_page;

  assign hw_guard  = pin_en_q & ~pin_n_i;
  assign stage_ok  = sr_stage & ~busy_i & arm_q & ~hw_guard;
  assign do_commit = pend_q & cycle_go & ~hw_guard;
  assign both_page = pend_d[B_IDSEL] & pend_d[B_LOCK];

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      pend_d <= '0;
    end else if (stage_ok) begin
      pend_q <= 1'b1;
      pend_d <= sr_data;
    end else if (hw_guard || do_commit) begin
      pend_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_en_q <= 1'b0;
      id_sel_q <= 1'b0;
      lock_q   <= 1'b0;
      bp_q     <= PROT_NONE;
      arm_q    <= 1'b0;
      busy_q   <= 1'b0;
    end else begin
      busy_q <= busy_i;
      if (do_commit) begin
        pin_en_q <= pend_d[B_PINEN];
        bp_q     <= prot_e'(pend_d[B_BPHI:B_BPLO]);
        if (!both_page) begin
          id_sel_q <= pend_d[B_IDSEL];
          lock_q   <= lock_q | pend_d[B_LOCK];
        end
      end
      if (xfer_done || wr_done) id_sel_q <= 1'b0;
      if (do_commit || wr_done || (cmd_wdis && !busy_i)) arm_q <= 1'b0;
      else if (cmd_wen && !busy_i) arm_q <= 1'b1;
    end
  end

  assign pin_en_o   = pin_en_q;
  assign id_sel_o   = id_sel_q;
  assign lock_o     = lock_q;
  assign bp_o       = bp_q;
  assign arm_o      = arm_q;
  assign busy_bit_o = busy_q;

  // R10
  wdone_clears_arm_chk: assert property (@(posedge clk) disable iff (rst)
    wr_done |=> !arm_q);
  // R5
  guard_cancels_pend_chk: assert property (@(posedge clk) disable iff (rst)
    (pend_q && hw_guard) |=> !pend_q);
  // R8
  both_page_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (do_commit && both_page && !xfer_done && !wr_done) |=> ($stable(id_sel_q) && $stable(lock_q)));
  // R9
  lock_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> lock_q);
  // R11
  busy_no_arm_chk: assert property (@(posedge clk) disable iff (rst)
    (busy_i && !arm_q) |=> !arm_q);
  // R3
  busy_mirror_hi_chk: assert property (@(posedge clk) disable iff (rst)
    busy_i |=> busy_q);
endmodule

// File: rtl/memstat_permit.sv
module memstat_permit #(
  parameter int AW  = 16,
  parameter int IDW = 7
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               pin_n_i,
  input  logic               pin_en_i,
  input  logic               arm_i,
  input  logic               id_sel_i,
  input  logic               lock_i,
  input  memstat_pkg::prot_e bp_i,
  input  logic [AW-1:0]      addr_i,
  output logic               sr_ok_o,
  output logic               arr_ok_o
);
  import memstat_pkg::*;

  localparam int PADW = AW - IDW;

  logic [AW-1:0] id_addr;
  logic          hit_main, hit_id, arr_next, sr_next;

  assign id_addr = {{PADW{1'b0}}, addr_i[IDW-1:0]};

  memstat_range #(.AW(AW)) u_rng_main (.addr_i(addr_i),  .bp_i(bp_i), .hit_o(hit_main));
  memstat_range #(.AW(AW)) u_rng_id   (.addr_i(id_addr), .bp_i(bp_i), .hit_o(hit_id));

  always_comb begin
    sr_next = arm_i & ~(pin_en_i & ~pin_n_i);
    if (id_sel_i) arr_next = arm_i & ~lock_i & (bp_i != PROT_ALL) & ~hit_id;
    else          arr_next = arm_i & ~hit_main;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_ok_o  <= 1'b0;
      arr_ok_o <= 1'b0;
    end else begin
      sr_ok_o  <= sr_next;
      arr_ok_o <= arr_next;
    end
  end

  // R6
  full_block_chk: assert property (@(posedge clk) disable iff (rst)
    arr_ok_o |-> ($past(bp_i) != PROT_ALL));
  // R4
  sr_guard_chk: assert property (@(posedge clk) disable iff (rst)
    sr_ok_o |-> $past(arm_i && !(pin_en_i && !pin_n_i)));
  // R7
  id_lock_chk: assert property (@(posedge clk) disable iff (rst)
    arr_ok_o |-> !$past(id_sel_i && lock_i));
endmodule

// File: rtl/memstat_guard.sv
module memstat_guard #(
  parameter int AW  = 16,
  parameter int IDW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          guard_pin_n,
  input  logic          cmd_wen,
  input  logic          cmd_wdis,
  input  logic          sr_stage,
  input  logic [7:0]    sr_data,
  input  logic          cycle_go,
  input  logic          wr_done,
  input  logic          xfer_done,
  input  logic          busy_i,
  input  logic [AW-1:0] addr_i,
  output logic [7:0]    stat_o,
  output logic          sr_ok_o,
  output logic          arr_ok_o,
  output logic          id_sel_o
);
  import memstat_pkg::*;

  logic  pin_en, id_sel, lock, arm, busy_bit;
  prot_e bp;

  memstat_regs u_regs (
    .clk(clk), .rst(rst), .pin_n_i(guard_pin_n),
    .cmd_wen(cmd_wen), .cmd_wdis(cmd_wdis),
    .sr_stage(sr_stage), .sr_data(sr_data), .cycle_go(cycle_go),
    .wr_done(wr_done), .xfer_done(xfer_done), .busy_i(busy_i),
    .pin_en_o(pin_en), .id_sel_o(id_sel), .lock_o(lock),
    .bp_o(bp), .arm_o(arm), .busy_bit_o(busy_bit)
  );

  memstat_permit #(.AW(AW), .IDW(IDW)) u_permit (
    .clk(clk), .rst(rst), .pin_n_i(guard_pin_n),
    .pin_en_i(pin_en), .arm_i(arm), .id_sel_i(id_sel), .lock_i(lock),
    .bp_i(bp), .addr_i(addr_i),
    .sr_ok_o(sr_ok_o), .arr_ok_o(arr_ok_o)
  );

  always_comb begin
    stat_o                = '0;
    stat_o[B_PINEN]       = pin_en;
    stat_o[B_IDSEL]       = id_sel;
    stat_o[B_ZERO]        = 1'b0;
    stat_o[B_LOCK]        = lock;
    stat_o[B_BPHI:B_BPLO] = bp;
    stat_o[B_ARM]         = arm;
    stat_o[B_BUSY]        = busy_bit;
  end

  assign id_sel_o = id_sel;

  // R2
  disarm_wins_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_wdis && !busy_i) |=> !stat_o[B_ARM]);
  // R3
  busy_mirror_lo_chk: assert property (@(posedge clk) disable iff (rst)
    !busy_i |=> !stat_o[B_BUSY]);
endmodule

// File: tb/memstat_guard_bench.sv
module memstat_guard_bench;
  localparam int AW = 16;

  typedef struct packed {
    logic [2:0]  op;
    logic        pin_n;
    logic [7:0]  data;
    logic [15:0] addr;
    logic [7:0]  st;
    logic        sr;
    logic        arr;
    logic [3:0]  req;
  } vec_t;

  localparam logic [2:0] NOP = 3'd0, ARM = 3'd1, DIS = 3'd2, SRW = 3'd3, WDN = 3'd4, XDN = 3'd5;
  localparam int NV = 31;

  localparam vec_t VEC [NV] = '{
    '{NOP, 1'b1, 8'h00, 16'h0000, 8'h00, 1'b0, 1'b0, 4'd1},   // R1
    '{SRW, 1'b1, 8'hFF, 16'h0000, 8'h00, 1'b0, 1'b0, 4'd4},   // R4 unarmed
    '{ARM, 1'b1, 8'h00, 16'h0000, 8'h02, 1'b1, 1'b1, 4'd2},   // R2
    '{SRW, 1'b1, 8'h8C, 16'h0000, 8'h8C, 1'b0, 1'b0, 4'd4},
    '{ARM, 1'b1, 8'h00, 16'h0000, 8'h8E, 1'b1, 1'b0, 4'd6},   // R6 full
    '{ARM, 1'b0, 8'h00, 16'h0000, 8'h8E, 1'b0, 1'b0, 4'd4},   // guard on
    '{SRW, 1'b0, 8'h00, 16'h0000, 8'h8E, 1'b0, 1'b0, 4'd4},   // refused
    '{SRW, 1'b1, 8'h04, 16'h0000, 8'h04, 1'b0, 1'b0, 4'd4},
    '{ARM, 1'b1, 8'h00, 16'hC000, 8'h06, 1'b1, 1'b0, 4'd6},   // R6 quarter
    '{NOP, 1'b1, 8'h00, 16'hBFFF, 8'h06, 1'b1, 1'b1, 4'd6},
    '{SRW, 1'b1, 8'h08, 16'h7FFF, 8'h08, 1'b0, 1'b0, 4'd4},
    '{ARM, 1'b1, 8'h00, 16'h8000, 8'h0A, 1'b1, 1'b0, 4'd6},   // R6 half
    '{NOP, 1'b1, 8'h00, 16'h7FFF, 8'h0A, 1'b1, 1'b1, 4'd6},
    '{DIS, 1'b1, 8'h00, 16'h7FFF, 8'h08, 1'b0, 1'b0, 4'd2},
    '{ARM, 1'b0, 8'h00, 16'h7FFF, 8'h0A, 1'b1, 1'b1, 4'd4},   // pin-enable off
    '{SRW, 1'b0, 8'h50, 16'h7FFF, 8'h00, 1'b0, 1'b0, 4'd8},   // R8
    '{ARM, 1'b1, 8'h00, 16'h7FFF, 8'h02, 1'b1, 1'b1, 4'd2},
    '{SRW, 1'b1, 8'h40, 16'h0005, 8'h40, 1'b0, 1'b0, 4'd3},
    '{ARM, 1'b1, 8'h00, 16'h0005, 8'h42, 1'b1, 1'b1, 4'd7},   // R7
    '{XDN, 1'b1, 8'h00, 16'h0005, 8'h02, 1'b1, 1'b1, 4'd10},  // R10
    '{SRW, 1'b1, 8'h44, 16'h0000, 8'h44, 1'b0, 1'b0, 4'd4},
    '{ARM, 1'b1, 8'h00, 16'h0000, 8'h46, 1'b1, 1'b1, 4'd7},
    '{WDN, 1'b1, 8'h00, 16'h0000, 8'h04, 1'b0, 1'b0, 4'd10},
    '{ARM, 1'b1, 8'h00, 16'h0000, 8'h06, 1'b1, 1'b1, 4'd2},
    '{SRW, 1'b1, 8'h4C, 16'h0000, 8'h4C, 1'b0, 1'b0, 4'd4},
    '{ARM, 1'b1, 8'h00, 16'h0000, 8'h4E, 1'b1, 1'b0, 4'd7},   // id page full
    '{SRW, 1'b1, 8'h10, 16'h0000, 8'h10, 1'b0, 1'b0, 4'd4},
    '{ARM, 1'b1, 8'h00, 16'h0000, 8'h12, 1'b1, 1'b1, 4'd6},
    '{SRW, 1'b1, 8'h40, 16'h0000, 8'h50, 1'b0, 1'b0, 4'd9},   // R9
    '{ARM, 1'b1, 8'h00, 16'h0000, 8'h52, 1'b1, 1'b0, 4'd7},   // locked page
    '{SRW, 1'b1, 8'h00, 16'h0000, 8'h10, 1'b0, 1'b0, 4'd9}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          guard_pin_n = 1'b1;
  logic          cmd_wen = 1'b0, cmd_wdis = 1'b0, sr_stage = 1'b0, cycle_go = 1'b0;
  logic          wr_done = 1'b0, xfer_done = 1'b0, busy_i = 1'b0;
  logic [7:0]    sr_data = '0;
  logic [AW-1:0] addr_i = '0;
  logic [7:0]    stat_o;
  logic          sr_ok_o, arr_ok_o, id_sel_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  memstat_guard #(.AW(AW)) u_memstat_guard (
    .clk(clk), .rst(rst), .guard_pin_n(guard_pin_n),
    .cmd_wen(cmd_wen), .cmd_wdis(cmd_wdis), .sr_stage(sr_stage),
    .sr_data(sr_data), .cycle_go(cycle_go), .wr_done(wr_done),
    .xfer_done(xfer_done), .busy_i(busy_i), .addr_i(addr_i),
    .stat_o(stat_o), .sr_ok_o(sr_ok_o), .arr_ok_o(arr_ok_o), .id_sel_o(id_sel_o)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_op(input logic [2:0] op, input logic [7:0] d);
    @(negedge clk);
    case (op)
      ARM: cmd_wen = 1'b1;
      DIS: cmd_wdis = 1'b1;
      SRW: begin sr_stage = 1'b1; sr_data = d; end
      WDN: wr_done = 1'b1;
      XDN: xfer_done = 1'b1;
      default: ;
    endcase
    @(negedge clk);
    cmd_wen = 1'b0; cmd_wdis = 1'b0; sr_stage = 1'b0; wr_done = 1'b0; xfer_done = 1'b0;
    if (op == SRW) begin
      cycle_go = 1'b1;
      @(negedge clk);
      cycle_go = 1'b0;
    end
  endtask

  task automatic settle();
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state, sampled while reset is held and after release
    check(stat_o == 8'h00, "R1 stat in reset", stat_o, 8'h00);
    check(!sr_ok_o && !arr_ok_o, "R1 permits in reset", {sr_ok_o, arr_ok_o}, 0);
    rst = 1'b0;
    settle();
    check(stat_o == 8'h00, "R1 stat after reset", stat_o, 8'h00);
    check(id_sel_o == 1'b0, "R1 id select", id_sel_o, 0);

    for (int i = 0; i < NV; i++) begin
      guard_pin_n = VEC[i].pin_n;
      addr_i      = VEC[i].addr;
      do_op(VEC[i].op, VEC[i].data);
      settle();
      check(stat_o == VEC[i].st, $sformatf("R%0d stat vec %0d", VEC[i].req, i), stat_o, VEC[i].st);
      check(sr_ok_o == VEC[i].sr, $sformatf("R4 status permit vec %0d", i), sr_ok_o, VEC[i].sr);
      check(arr_ok_o == VEC[i].arr, $sformatf("R%0d write permit vec %0d", VEC[i].req, i), arr_ok_o, VEC[i].arr);
      check(id_sel_o == VEC[i].st[6], $sformatf("R3 id select vec %0d", i), id_sel_o, VEC[i].st[6]);
    end

    // R2 simultaneous arm and disarm: disarm wins
    @(negedge clk); cmd_wen = 1'b1; cmd_wdis = 1'b1;
    @(negedge clk); cmd_wen = 1'b0; cmd_wdis = 1'b0;
    settle();
    check(stat_o == 8'h10, "R2 disarm wins", stat_o, 8'h10);

    // R5 guard falls between staging and start: write dropped
    do_op(ARM, 8'h00);
    do_op(SRW, 8'h90);
    do_op(ARM, 8'h00);
    settle();
    check(stat_o == 8'h92, "R5 setup", stat_o, 8'h92);
    @(negedge clk); sr_stage = 1'b1; sr_data = 8'h94;
    @(negedge clk); sr_stage = 1'b0; guard_pin_n = 1'b0;
    @(negedge clk); cycle_go = 1'b1;
    @(negedge clk); cycle_go = 1'b0;
    settle();
    check(stat_o == 8'h92, "R5 cancelled write", stat_o, 8'h92);
    guard_pin_n = 1'b1;
    settle();
    check(sr_ok_o == 1'b1, "R4 guard released", sr_ok_o, 1);

    // R5 guard falls after the write applied: no effect
    do_op(SRW, 8'h94);
    guard_pin_n = 1'b0;
    settle();
    check(stat_o == 8'h94, "R5 applied write kept", stat_o, 8'h94);
    guard_pin_n = 1'b1;

    // R11 busy: bit 0 follows, strobes ignored
    busy_i = 1'b1;
    settle();
    check(stat_o == 8'h95, "R3 busy bit", stat_o, 8'h95);
    do_op(ARM, 8'h00);
    settle();
    check(stat_o == 8'h95, "R11 arm ignored while busy", stat_o, 8'h95);
    busy_i = 1'b0;
    settle();
    check(stat_o == 8'h94, "R3 busy cleared", stat_o, 8'h94);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end
endmodule